// File: doc/BRIEF.md
# Dual Tick Compare Timer

This block keeps a free-running system tick count and watches it with two independent compare channels. One channel serves the supervisor level and the other serves the hypervisor level. Software loads each channel through a single write port and can read either channel back through a read port. When the tick count reaches the low 63 bits of an armed channel, that channel raises a set strobe for one cycle. The supervisor strobe is meant to set bit 16 of the soft-interrupt register. The hypervisor strobe is meant to set the hypervisor interrupt-pending register to 1.

The top bit of each compare register is a disable flag. It is stored and read back like any other bit, but it takes no part in the equality test. When it is set, the channel stays silent, so rewriting a channel with the flag set withdraws a match that has not yet happened. A per-thread halted input silences the hypervisor channel only. The supervisor strobe still fires while the thread is halted or suspended, so the timer can wake a sleeping thread. A compare value that the count has already passed stays quiet until the count wraps round to it.

Reset is asserted asynchronously and released through a synchroniser. Reset clears the count and sets the disable flag in both channels.

Top module: `tick_cmp_unit`

## Requirements
- R1: While reset is active, and straight after it, tick_count_o is 0, both channels read back 0x8000_0000_0000_0000 (disable flag set), and both strobes are low.
- R2: Once reset has been released, tick_count_o increases by exactly one on every clock cycle and wraps modulo 2^63.
- R3: A write with wr_en_i high loads all 64 bits of wr_data_i into the channel chosen by wr_sel_i (0 = supervisor, 1 = hypervisor) at the next clock edge. rd_data_o shows the channel chosen by rd_sel_i (0 = supervisor, 1 = hypervisor), including bit 63. The other channel keeps its value.
- R4: soft_int_set_o is high exactly in the cycles where tick_count_o equals bits 62:0 of the supervisor channel and that channel's bit 63 is 0. In free running it is high for only one cycle.
- R5: A channel whose bit 63 is 1 never raises its strobe, whatever its low 63 bits hold.
- R6: hyp_int_set_o follows the rule of R4 for the hypervisor channel while thread_halted_i is low.
- R7: While thread_halted_i is high, hyp_int_set_o stays low. thread_halted_i has no effect on soft_int_set_o.
- R8: Rewriting a channel with bit 63 set before the count reaches its value cancels that match. No strobe follows.
- R9: A channel loaded with a value below the current count does not fire until the count wraps round to that value.
- R10: A newly written value takes part in the comparison from the cycle after the write edge. A value one greater than the count seen in the write cycle therefore fires in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_sel_i | input | 1 | Write target: 0 supervisor, 1 hypervisor |
| wr_data_i | input | 64 | Write data; bit 63 is the disable flag |
| rd_sel_i | input | 1 | Read source: 0 supervisor, 1 hypervisor |
| rd_data_o | output | 64 | Selected compare register contents |
| thread_halted_i | input | 1 | Thread is halted; masks the hypervisor channel |
| tick_count_o | output | 63 | Current system tick count |
| soft_int_set_o | output | 1 | Supervisor match: set soft-interrupt bit 16 |
| hyp_int_set_o | output | 1 | Hypervisor match: set hypervisor interrupt pending |

## Verification
The bound checker watches these rules on every cycle:
- The count steps by one.
- A write lands in the selected channel.
- A strobe occurs only when its channel's flag is clear and its low bits equal the count.
- A strobe never lasts two cycles unless the channel is rewritten.
- The hypervisor strobe is low while the thread is halted.

Only the bench's scenarios can show the cycle in which each strobe fires after a write, and that the timing is the same at different distances. The same holds for a cancellation that takes effect before the match, for a value already passed staying silent, and for the reset read-back values.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned SUP_IDX = 0;
  localparam int unsigned HYP_IDX = 1;

  typedef enum logic {
    SEL_SUP = 1'b0,
    SEL_HYP = 1'b1
  } cmp_sel_e;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tick_cmp_channel.sv
module tick_cmp_channel #(
  parameter int unsigned CNT_W = 63,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CMP_W-1:0] ld_data,
  input  logic [CNT_W-1:0] count_i,
  input  logic             mask_i,
  output logic [CMP_W-1:0] value_o,
  output logic             hit_o
);
  logic [CMP_W-1:0] val_q;
  logic [CMP_W-1:0] val_d;
  logic             armed;
  logic             equal;

  always_comb begin
    val_d = val_q;
    if (ld_en) begin
      val_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= {1'b1, {CNT_W{1'b0}}};
    end else begin
      val_q <= val_d;
    end
  end

  always_comb begin
    armed = ~val_q[CMP_W-1];
    equal = (val_q[CNT_W-1:0] == count_i);
    hit_o = armed & equal & ~mask_i;
  end

  assign value_o = val_q;
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = 63,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CMP_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [CMP_W-1:0] rd_data_o,
  input  logic             thread_halted_i,
  output logic [CNT_W-1:0] tick_count_o,
  output logic             soft_int_set_o,
  output logic             hyp_int_set_o
);
  logic             srst_n;
  logic [CNT_W-1:0] count;
  logic [NUM_CH-1:0] ld_en;
  logic [NUM_CH-1:0] ch_mask;
  logic [NUM_CH-1:0] ch_hit;
  logic [CMP_W-1:0] ch_val [NUM_CH];
  logic [CMP_W-1:0] sup_val;
  logic [CMP_W-1:0] hyp_val;
  cmp_sel_e         wsel;
  cmp_sel_e         rsel;

  tick_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (srst_n),
    .cnt_en  (1'b1),
    .count_o (count)
  );

  assign wsel = cmp_sel_e'(wr_sel_i);
  assign rsel = cmp_sel_e'(rd_sel_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam cmp_sel_e CH_SEL = (g == HYP_IDX) ? SEL_HYP : SEL_SUP;

    assign ld_en[g]   = wr_en_i && (wsel == CH_SEL);
    assign ch_mask[g] = (g == HYP_IDX) ? thread_halted_i : 1'b0;

    tick_cmp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (srst_n),
      .ld_en   (ld_en[g]),
      .ld_data (wr_data_i),
      .count_i (count),
      .mask_i  (ch_mask[g]),
      .value_o (ch_val[g]),
      .hit_o   (ch_hit[g])
    );
  end

  assign sup_val = ch_val[SUP_IDX];
  assign hyp_val = ch_val[HYP_IDX];

  always_comb begin
    rd_data_o = (rsel == SEL_HYP) ? hyp_val : sup_val;
  end

  assign tick_count_o   = count;
  assign soft_int_set_o = ch_hit[SUP_IDX];
  assign hyp_int_set_o  = ch_hit[HYP_IDX];
endmodule

// File: rtl/tick_cmp_checker.sv
module tick_cmp_checker #(
  parameter int unsigned CNT_W = 63,
  localparam int unsigned CMP_W = CNT_W + 1
) (
  input logic             clk,
  input logic             srst_n,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [CMP_W-1:0] wr_data_i,
  input logic             thread_halted_i,
  input logic [CNT_W-1:0] tick_count_o,
  input logic             soft_int_set_o,
  input logic             hyp_int_set_o,
  input logic [CMP_W-1:0] sup_val,
  input logic [CMP_W-1:0] hyp_val
);
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> tick_count_o == $past(tick_count_o) + 1'b1);

  assert_sup_load_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en_i && !wr_sel_i) |=> sup_val == $past(wr_data_i));

  assert_hyp_load_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en_i && wr_sel_i) |=> hyp_val == $past(wr_data_i));

  assert_sup_hit_R4: assert property (@(posedge clk) disable iff (!srst_n)
    soft_int_set_o |-> (sup_val[CNT_W-1:0] == tick_count_o));

  assert_sup_single_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (soft_int_set_o && !(wr_en_i && !wr_sel_i)) |=> !soft_int_set_o);

  assert_sup_disabled_R5: assert property (@(posedge clk) disable iff (!srst_n)
    sup_val[CNT_W] |-> !soft_int_set_o);

  assert_hyp_disabled_R5: assert property (@(posedge clk) disable iff (!srst_n)
    hyp_val[CNT_W] |-> !hyp_int_set_o);

  assert_hyp_hit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    hyp_int_set_o |-> (hyp_val[CNT_W-1:0] == tick_count_o));

  assert_halt_mask_R7: assert property (@(posedge clk) disable iff (!srst_n)
    thread_halted_i |-> !hyp_int_set_o);
endmodule

bind tick_cmp_unit tick_cmp_checker #(.CNT_W(CNT_W)) u_tick_cmp_checker (
  .clk             (clk),
  .srst_n          (srst_n),
  .wr_en_i         (wr_en_i),
  .wr_sel_i        (wr_sel_i),
  .wr_data_i       (wr_data_i),
  .thread_halted_i (thread_halted_i),
  .tick_count_o    (tick_count_o),
  .soft_int_set_o  (soft_int_set_o),
  .hyp_int_set_o   (hyp_int_set_o),
  .sup_val         (sup_val),
  .hyp_val         (hyp_val)
);

// File: tb/test_tick_cmp_unit.sv
`timescale 1ns/1ps
module test_tick_cmp_unit;
  localparam int unsigned CNT_W = 63;
  localparam int unsigned CMP_W = CNT_W + 1;
  localparam logic [CMP_W-1:0] RST_VAL = {1'b1, {CNT_W{1'b0}}};

  typedef struct packed {
    logic       hyp;
    logic       dis;
    logic       halt;
    logic [7:0] dly;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{hyp: 1'b0, dis: 1'b0, halt: 1'b0, dly: 8'd3},
    '{hyp: 1'b0, dis: 1'b0, halt: 1'b1, dly: 8'd5},
    '{hyp: 1'b0, dis: 1'b1, halt: 1'b0, dly: 8'd4},
    '{hyp: 1'b1, dis: 1'b0, halt: 1'b0, dly: 8'd2},
    '{hyp: 1'b1, dis: 1'b0, halt: 1'b1, dly: 8'd6},
    '{hyp: 1'b1, dis: 1'b1, halt: 1'b0, dly: 8'd3},
    '{hyp: 1'b0, dis: 1'b0, halt: 1'b0, dly: 8'd1},
    '{hyp: 1'b1, dis: 1'b0, halt: 1'b0, dly: 8'd7}
  };

  logic             clk;
  logic             rst_n;
  logic             wr_en_i;
  logic             wr_sel_i;
  logic [CMP_W-1:0] wr_data_i;
  logic             rd_sel_i;
  logic [CMP_W-1:0] rd_data_o;
  logic             thread_halted_i;
  logic [CNT_W-1:0] tick_count_o;
  logic             soft_int_set_o;
  logic             hyp_int_set_o;

  int total = 0;
  int bad   = 0;
  logic [CMP_W-1:0] sup_m;
  logic [CMP_W-1:0] hyp_m;

  tick_cmp_unit #(.CNT_W(CNT_W)) i_tick_cmp_unit (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en_i         (wr_en_i),
    .wr_sel_i        (wr_sel_i),
    .wr_data_i       (wr_data_i),
    .rd_sel_i        (rd_sel_i),
    .rd_data_o       (rd_data_o),
    .thread_halted_i (thread_halted_i),
    .tick_count_o    (tick_count_o),
    .soft_int_set_o  (soft_int_set_o),
    .hyp_int_set_o   (hyp_int_set_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [CMP_W-1:0] act,
                       input logic [CMP_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ch(input logic hyp, input logic [CMP_W-1:0] data);
    wr_en_i   = 1'b1;
    wr_sel_i  = hyp;
    wr_data_i = data;
    if (hyp) hyp_m = data;
    else     sup_m = data;
  endtask

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] c;
    logic [CNT_W-1:0] prev;
    rst_n = 1'b0;
    wr_en_i = 1'b0;
    wr_sel_i = 1'b0;
    wr_data_i = '0;
    rd_sel_i = 1'b0;
    thread_halted_i = 1'b0;
    sup_m = RST_VAL;
    hyp_m = RST_VAL;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 count", CMP_W'(tick_count_o), '0);
    rd_sel_i = 1'b0; #0.1;
    check("R1 sup read", rd_data_o, RST_VAL);
    rd_sel_i = 1'b1; #0.1;
    check("R1 hyp read", rd_data_o, RST_VAL);
    check("R1 strobes", CMP_W'({soft_int_set_o, hyp_int_set_o}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: counter steps by one
    prev = tick_count_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 step", CMP_W'(tick_count_o), CMP_W'(prev + 1'b1));
      prev = tick_count_o;
    end

    // R4 R5 R6 R7 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      c = tick_count_o;
      thread_halted_i = VEC[v].halt;
      write_ch(VEC[v].hyp, {VEC[v].dis, c + CNT_W'(VEC[v].dly)});
      for (int j = 1; j <= int'(VEC[v].dly) + 2; j++) begin
        logic exp_s;
        logic exp_h;
        @(negedge clk);
        wr_en_i = 1'b0;
        exp_s = !VEC[v].hyp && !VEC[v].dis && (j == int'(VEC[v].dly));
        exp_h = VEC[v].hyp && !VEC[v].dis && !VEC[v].halt
                && (j == int'(VEC[v].dly));
        check("R4 R5 R7 R10 supervisor strobe", CMP_W'(soft_int_set_o), CMP_W'(exp_s));
        check("R6 R5 R7 hypervisor strobe", CMP_W'(hyp_int_set_o), CMP_W'(exp_h));
      end
      rd_sel_i = VEC[v].hyp; #0.1;
      check("R3 read written", rd_data_o, VEC[v].hyp ? hyp_m : sup_m);
      thread_halted_i = 1'b0;
    end

    // R3: load one channel, other keeps value
    write_ch(1'b0, 64'h8000_0000_1234_5678);
    @(negedge clk);
    wr_en_i = 1'b0;
    rd_sel_i = 1'b0; #0.1;
    check("R3 sup with flag", rd_data_o, 64'h8000_0000_1234_5678);
    rd_sel_i = 1'b1; #0.1;
    check("R3 hyp untouched", rd_data_o, hyp_m);

    // R8: cancel pending hypervisor match
    c = tick_count_o;
    write_ch(1'b1, {1'b0, c + CNT_W'(10)});
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      wr_en_i = 1'b0;
      if (j == 5) write_ch(1'b1, {1'b1, c + CNT_W'(10)});
      check("R8 cancelled", CMP_W'(hyp_int_set_o), '0);
    end
    @(negedge clk);
    wr_en_i = 1'b0;

    // R9: value already passed stays silent
    c = tick_count_o;
    write_ch(1'b0, {1'b0, c - CNT_W'(3)});
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      wr_en_i = 1'b0;
      check("R9 passed value", CMP_W'(soft_int_set_o), '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule